// File: doc/BRIEF.md
# Deferred-Start Control for a Memory-Expansion DMA Engine

This block decides when a memory-expansion DMA engine may begin a transfer. The host writes a command byte to a register at a fixed bus address. The top bit of that byte is the execute flag, and a second bit selects how the transfer starts. In immediate mode the engine receives a start pulse in the clock after the write. In deferred mode the command waits, armed, until the host writes any value to a separate trigger address. Until that write happens, the host can withdraw the command by writing the execute flag back to zero.

The trigger address usually belongs to an unrelated system register, such as a memory-banking control. One host write can therefore set up a memory map and also start the transfer. The host regains the bus on its next cycle and can restore its previous map. The command byte can be read back at all times. When the engine reports done, the execute flag clears and the block returns to rest.

The controller has three states. `ARM_IDLE` is at rest. `ARM_PENDING` is armed and waiting for the trigger. `ARM_BUSY` means a transfer is under way. The transitions are:
- idle or pending to busy on an immediate command (*launch*);
- idle or pending to pending on a deferred command (*arm*);
- pending to busy on a trigger write (*fire*);
- pending or idle to idle on a command with the execute flag clear (*cancel*);
- busy to idle on done (*retire*).

Top module: `dma_arm_ctrl`

## Requirements
- R1: After reset the state is idle, the command register reads 0x00 and the start output is low.
- R2: A write to the command address (0xDF01) with bit 7 = 1 and bit 4 = 0 raises the start output in the clock cycle after the write and enters the busy state. The register then reads bit 7 = 1.
- R3: A write to the command address with bit 7 = 1 and bit 4 = 1 arms the block. Bit 7 reads 1 and no start occurs for as long as no trigger write arrives.
- R4: While armed, a write of any data value to the trigger address (0xFF00) raises the start output in the following cycle and enters the busy state.
- R5: While armed, a command write with bit 7 = 0 cancels the command. Bit 7 reads 0, and a later trigger write produces no start.
- R6: A bus cycle on the trigger address with the write strobe low never starts a transfer. A trigger write while idle has no effect on the start output or on the register.
- R7: When the done input is high in the busy state, bit 7 of the register clears and the block returns to idle. The other bits keep their values.
- R8: In the busy state, trigger writes and command writes are ignored. The register holds its value and no further start is issued.
- R9: The start output is high for exactly one clock cycle per transfer.
- R10: Bits 6:0 of an accepted command write read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host bus address |
| host_wdata | input | 8 | Host bus write data |
| host_we | input | 1 | Host write strobe, one cycle per write |
| xfer_done | input | 1 | DMA engine reports the transfer finished |
| xfer_start | output | 1 | One-cycle start pulse to the DMA engine |
| cmd_value | output | 8 | Current command register contents |

## Verification
The assertions assume the following about the inputs:
- The write strobe marks a single host write per cycle, with the address and data valid in that same cycle.
- The done input carries meaning only while a transfer is running. Done in any other state is treated as noise.

The stimulus stays within these limits. Every write lasts exactly one cycle, and inputs change only on the falling edge. Done is raised only after a start pulse has been seen. The one exception is a single deliberate pulse while idle, which checks that it changes nothing.

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;
    typedef enum logic [1:0] {
        ARM_IDLE    = 2'd0,
        ARM_PENDING = 2'd1,
        ARM_BUSY    = 2'd2
    } arm_state_t;
endpackage

// File: rtl/dma_arm_decode.sv
module dma_arm_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CMD_ADDR  = 16'hDF01,
    parameter logic [15:0] TRIG_ADDR = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              cmd_wr,
    output logic              trig_wr
);
    localparam logic [ADDR_W-1:0] CMD_A  = CMD_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] TRIG_A = TRIG_ADDR[ADDR_W-1:0];

    // Only write cycles qualify; a read of either address decodes to nothing.
    always_comb begin
        cmd_wr  = we && (addr == CMD_A);
        trig_wr = we && (addr == TRIG_A);
    end
endmodule

// File: rtl/dma_arm_fsm.sv
module dma_arm_fsm
    import dma_arm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int EXEC_BIT  = 7,
    parameter int DEFER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    output arm_state_t        state,
    output logic              start,
    output logic              cmd_accept,
    output logic              exec_clear
);
    arm_state_t state_nx;
    logic       launch;

    always_comb begin
        state_nx   = state;
        launch     = 1'b0;
        cmd_accept = 1'b0;
        exec_clear = 1'b0;
        unique case (state)
            ARM_IDLE, ARM_PENDING: begin
                if (cmd_wr) begin
                    cmd_accept = 1'b1;
                    if (!wdata[EXEC_BIT]) begin
                        state_nx = ARM_IDLE;            // cancel
                    end else if (wdata[DEFER_BIT]) begin
                        state_nx = ARM_PENDING;         // arm
                    end else begin
                        state_nx = ARM_BUSY;            // launch
                        launch   = 1'b1;
                    end
                end else if (state == ARM_PENDING && trig_wr) begin
                    state_nx = ARM_BUSY;                // fire
                    launch   = 1'b1;
                end
            end
            ARM_BUSY: begin
                if (done) begin
                    state_nx   = ARM_IDLE;              // retire
                    exec_clear = 1'b1;
                end
            end
            default: state_nx = ARM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARM_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) start <= 1'b0;
        else        start <= launch;
    end

    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    assert_armed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARM_PENDING && !cmd_wr && !trig_wr) |=> (state == ARM_PENDING && !start));
    assert_trig_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARM_PENDING && trig_wr) |=> (start && state == ARM_BUSY));
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARM_IDLE && !cmd_wr) |=> !start);
    assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARM_BUSY) |=> !start);
    assert_done_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARM_BUSY && done) |=> (state == ARM_IDLE));
endmodule

// File: rtl/dma_arm_cmdreg.sv
module dma_arm_cmdreg #(
    parameter int DATA_W   = 8,
    parameter int EXEC_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear_exec,
    input  logic              busy,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= wdata;
        end else if (clear_exec) begin
            value[EXEC_BIT] <= 1'b0;
        end
    end

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear_exec) |=> $stable(value));
    assert_retire_keeps_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_exec |=> (value[EXEC_BIT] == 1'b0 && value[EXEC_BIT-1:0] == $past(value[EXEC_BIT-1:0])));
endmodule

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl
    import dma_arm_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] CMD_ADDR  = 16'hDF01,
    parameter logic [15:0] TRIG_ADDR = 16'hFF00,
    parameter int          EXEC_BIT  = 7,
    parameter int          DEFER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic              xfer_done,
    output logic              xfer_start,
    output logic [DATA_W-1:0] cmd_value
);
    logic       cmd_wr, trig_wr, cmd_accept, exec_clear;
    arm_state_t state;

    dma_arm_decode #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .TRIG_ADDR(TRIG_ADDR)
    ) u_decode (
        .addr(host_addr), .we(host_we), .cmd_wr(cmd_wr), .trig_wr(trig_wr)
    );

    dma_arm_fsm #(
        .DATA_W(DATA_W), .EXEC_BIT(EXEC_BIT), .DEFER_BIT(DEFER_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .trig_wr(trig_wr),
        .wdata(host_wdata), .done(xfer_done), .state(state),
        .start(xfer_start), .cmd_accept(cmd_accept), .exec_clear(exec_clear)
    );

    dma_arm_cmdreg #(
        .DATA_W(DATA_W), .EXEC_BIT(EXEC_BIT)
    ) u_cmdreg (
        .clk(clk), .rst_n(rst_n), .load(cmd_accept), .clear_exec(exec_clear),
        .busy(state == ARM_BUSY), .wdata(host_wdata), .value(cmd_value)
    );

    // The execute flag seen by the host mirrors "armed or running".
    assert_exec_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_value[EXEC_BIT] == (state != ARM_IDLE));
    assert_start_enters_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (state == ARM_BUSY || $past(xfer_done)));
endmodule

// File: tb/sim_dma_arm_ctrl.sv
module sim_dma_arm_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = 16'h0000;
    logic [7:0]  host_wdata = 8'h00;
    logic        host_we = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_start;
    logic [7:0]  cmd_value;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R1";

    // behavioural reference: 0 rest, 1 waiting, 2 running
    int       m_state = 0;
    bit [7:0] m_cmd = 8'h00;
    bit       m_start = 1'b0;
    int       start_count = 0;

    always #5 clk = ~clk;

    dma_arm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .xfer_done(xfer_done), .xfer_start(xfer_start),
        .cmd_value(cmd_value)
    );

    always @(posedge clk) begin
        bit nstart;
        nstart = 1'b0;
        if (!rst_n) begin
            m_state = 0; m_cmd = 8'h00;
        end else if (m_state == 2) begin
            if (xfer_done) begin m_state = 0; m_cmd[7] = 1'b0; end
        end else if (host_we && host_addr == 16'hDF01) begin
            m_cmd = host_wdata;
            if (!host_wdata[7])     m_state = 0;
            else if (host_wdata[4]) m_state = 1;
            else begin m_state = 2; nstart = 1'b1; end
        end else if (m_state == 1 && host_we && host_addr == 16'hFF00) begin
            m_state = 2; nstart = 1'b1;
        end
        m_start = nstart;
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare with the reference on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(phase, "start", int'(xfer_start), int'(m_start));
            check(phase, "cmd", int'(cmd_value), int'(m_cmd));
            if (xfer_start) start_count++;
        end
    end

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_addr = 16'h0000;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int sc;
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset cmd", int'(cmd_value), 0);
        check("R1", "reset start", int'(xfer_start), 0);

        // R2 immediate start, R9 one pulse, R10 low bits
        phase = "R2";
        sc = start_count;
        wr(16'hDF01, 8'h85);
        idle_cycles(3);
        check("R9", "immediate pulses", start_count - sc, 1);
        check("R10", "low bits", int'(cmd_value[6:0]), 7'h05);
        phase = "R8";
        wr(16'hFF00, 8'h11);
        wr(16'hDF01, 8'h00);
        check("R8", "cmd held busy", int'(cmd_value), 8'h85);
        phase = "R7";
        pulse_done();
        check("R7", "retire", int'(cmd_value), 8'h05);

        // R3 deferred, R4 trigger
        phase = "R3";
        sc = start_count;
        wr(16'hDF01, 8'hB2);
        idle_cycles(10);
        check("R3", "armed no start", start_count - sc, 0);
        check("R3", "armed flag", int'(cmd_value[7]), 1);
        phase = "R6";
        @(negedge clk); host_addr = 16'hFF00; host_we = 1'b0;
        idle_cycles(3);
        check("R6", "read no fire", start_count - sc, 0);
        phase = "R4";
        wr(16'hFF00, 8'h00);
        idle_cycles(2);
        check("R4", "fired", start_count - sc, 1);
        phase = "R8";
        wr(16'hFF00, 8'hFF);
        check("R8", "no refire", start_count - sc, 1);
        phase = "R7";
        pulse_done();
        check("R7", "retire deferred", int'(cmd_value), 8'h32);

        // R5 cancel
        phase = "R5";
        sc = start_count;
        wr(16'hDF01, 8'h9C);
        idle_cycles(2);
        wr(16'hDF01, 8'h1C);
        check("R5", "cancel flag", int'(cmd_value[7]), 0);
        wr(16'hFF00, 8'h42);
        idle_cycles(3);
        check("R5", "no start after cancel", start_count - sc, 0);

        // R6 idle trigger write, stray done while idle
        phase = "R6";
        wr(16'hFF00, 8'hA5);
        pulse_done();
        idle_cycles(2);
        check("R6", "idle trigger", start_count - sc, 0);
        check("R6", "idle cmd kept", int'(cmd_value), 8'h1C);

        // deferred then immediate override while armed, R2
        phase = "R2";
        wr(16'hDF01, 8'h90);
        wr(16'hDF01, 8'h80);
        idle_cycles(2);
        check("R2", "override launches", start_count - sc, 1);
        pulse_done();
        idle_cycles(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule